// File: doc/BRIEF.md
# Packed-Pixel Access Data Path

This block sits on the data side of a graphics address translator. Every access a master makes into one of the virtual frame buffers passes through it once the translator has decided which buffer the access hits and whether the address is backed by physical memory. The block decides what reaches memory on a write and what returns to the master on a read. Buffers that hold 24-bit pixels can be set to appear to masters as 32-bit words. On a write one byte of each word is then discarded. On a read the missing byte is filled with a programmable alpha value.

Packing is configured per buffer. Each buffer has an enable bit and a byte-select bit. The enable takes effect only when the 12-byte block size is in force. When 16-byte blocks are selected, every buffer passes whole words through. Accesses that the translator reports as unmapped never reach memory. Such a write leaves with all byte lanes off. Such a read returns a programmable 32-bit constant.

The block is a small beat state machine. In `ST_IDLE` nothing is presented. An accepted request moves it to one of four result states, and the result is shown for exactly one cycle:
- `ST_WR_PASS`: a mapped write.
- `ST_WR_DROP`: an unmapped write.
- `ST_RD_MAPPED`: a mapped read.
- `ST_RD_DEFAULT`: an unmapped read.

From any state, the transitions are: `req_valid` low goes to `ST_IDLE`; a write goes to `ST_WR_PASS` or `ST_WR_DROP` by `req_mapped`; a read goes to `ST_RD_MAPPED` or `ST_RD_DEFAULT` by `req_mapped`. Back-to-back requests therefore stream at one per cycle.

Top module: `gfx_pack_path`

## Requirements
- R1: After reset `wr_valid` and `rd_valid` are 0 and `wr_strb` is 4'b0000; `wr_strb` is 4'b0000 whenever `wr_valid` is 0.
- R2: With `cfg_blk12` = 0 (16-byte blocks), packing enables are ignored: a mapped write gives `wr_strb` = 4'b1111 and a mapped read returns `mem_rdata` unchanged.
- R3: With `cfg_blk12` = 1, packing enabled and byte-select 0 for the addressed buffer, a mapped write gives `wr_strb` = 4'b0111 (lane 3, bits 31:24, dropped).
- R4: With `cfg_blk12` = 1, packing enabled and byte-select 1, a mapped write gives `wr_strb` = 4'b1110 (lane 0, bits 7:0, dropped).
- R5: A mapped packed read with byte-select 0 returns `{cfg_alpha, mem_rdata[23:0]}`.
- R6: A mapped packed read with byte-select 1 returns `{mem_rdata[31:8], cfg_alpha}`.
- R7: The enable and select used are bits `cfg_pack_en[req_buf]` and `cfg_pack_lsb[req_buf]`; other buffers' bits have no effect on the access.
- R8: An unmapped write is presented with `wr_valid` = 1 and `wr_strb` = 4'b0000.
- R9: An unmapped read returns `cfg_dflt_word`, whatever the packing configuration.
- R10: A request accepted at a clock edge produces its result (`wr_valid` for writes, `rd_valid` for reads, never both) during the following cycle only; with no request the next cycle shows neither.
- R11: With `cfg_blk12` = 1 and packing disabled for the buffer, mapped writes use `wr_strb` = 4'b1111 and mapped reads return `mem_rdata` unchanged.
- R12: On a mapped write `wr_data` equals the master's `req_wdata`, with lanes in their original positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_buf | input | 2 | Virtual buffer index from translation |
| req_mapped | input | 1 | Translation found a physical mapping |
| req_wdata | input | 32 | Master write word |
| mem_rdata | input | 32 | Word read from physical memory for this access |
| cfg_blk12 | input | 1 | 1 = 12-byte blocks, 0 = 16-byte blocks |
| cfg_pack_en | input | 4 | Per-buffer packing enable |
| cfg_pack_lsb | input | 4 | Per-buffer byte select: 0 drops top byte, 1 drops bottom byte |
| cfg_alpha | input | 8 | Fill byte for packed reads |
| cfg_dflt_word | input | 32 | Read result for unmapped addresses |
| wr_valid | output | 1 | Write beat to memory |
| wr_strb | output | 4 | Byte-lane enables of the write beat |
| wr_data | output | 32 | Write beat data |
| rd_valid | output | 1 | Read result to master |
| rd_data | output | 32 | Read result word |

## Verification
The assertions take for granted that `mem_rdata` and every configuration input belong to the accepted access: they are stable in the request cycle and are the values the result must reflect. The unmapped-read property compares against the default word seen one cycle earlier. The bench drives each access, with its memory word and configuration, half a cycle before the capturing edge and holds it until the result is sampled. Random vectors draw every field freely inside these rules. Directed vectors pin the cases where the block-size bit overrides an enabled buffer, where neighbouring buffers carry the opposite configuration, and where idle cycles follow traffic.

// File: rtl/gfx_pack_pkg.sv
package gfx_pack_pkg;

    // Effective byte handling for one access
    typedef enum logic [1:0] {
        PK_FULL    = 2'd0,
        PK_DROP_HI = 2'd1,
        PK_DROP_LO = 2'd2
    } pack_mode_e;

    // Result currently presented on the outputs
    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_WR_PASS    = 3'd1,
        ST_WR_DROP    = 3'd2,
        ST_RD_MAPPED  = 3'd3,
        ST_RD_DEFAULT = 3'd4
    } beat_state_e;

endpackage

// File: rtl/gfx_pack_mode_sel.sv
module gfx_pack_mode_sel
    import gfx_pack_pkg::*;
#(
    parameter int NUM_BUF = 4,
    parameter int IDX_W   = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic [IDX_W-1:0]   buf_idx,
    input  logic               blk12,
    input  logic [NUM_BUF-1:0] pack_en,
    input  logic [NUM_BUF-1:0] pack_lsb,
    output pack_mode_e         mode
);

    pack_mode_e per_buf [NUM_BUF];

    for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
        always_comb begin
            if (!blk12 || !pack_en[b]) begin
                per_buf[b] = PK_FULL;
            end else if (pack_lsb[b]) begin
                per_buf[b] = PK_DROP_LO;
            end else begin
                per_buf[b] = PK_DROP_HI;
            end
        end
    end

    always_comb begin
        mode = PK_FULL;
        for (int b = 0; b < NUM_BUF; b++) begin
            if (buf_idx == IDX_W'(b)) begin
                mode = per_buf[b];
            end
        end
    end

endmodule

// File: rtl/gfx_pack_lane_strobe.sv
module gfx_pack_lane_strobe
    import gfx_pack_pkg::*;
#(
    parameter int LANES = 4
) (
    input  pack_mode_e       mode,
    output logic [LANES-1:0] strb
);

    localparam int TOP_LANE = LANES - 1;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_comb begin
            unique case (mode)
                PK_DROP_HI: strb[l] = (l != TOP_LANE);
                PK_DROP_LO: strb[l] = (l != 0);
                default:    strb[l] = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/gfx_pack_read_merge.sv
module gfx_pack_read_merge
    import gfx_pack_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LANE_W = 8
) (
    input  pack_mode_e        mode,
    input  logic [WORD_W-1:0] mem_word,
    input  logic [LANE_W-1:0] alpha,
    output logic [WORD_W-1:0] merged
);

    localparam int LANES    = WORD_W / LANE_W;
    localparam int TOP_LANE = LANES - 1;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic refill;
        always_comb begin
            unique case (mode)
                PK_DROP_HI: refill = (l == TOP_LANE);
                PK_DROP_LO: refill = (l == 0);
                default:    refill = 1'b0;
            endcase
            merged[l*LANE_W +: LANE_W] = refill ? alpha
                                                : mem_word[l*LANE_W +: LANE_W];
        end
    end

endmodule

// File: rtl/gfx_pack_path.sv
module gfx_pack_path
    import gfx_pack_pkg::*;
#(
    parameter int NUM_BUF = 4,
    parameter int WORD_W  = 32,
    parameter int LANE_W  = 8,
    localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
    localparam int LANES  = WORD_W / LANE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [IDX_W-1:0]   req_buf,
    input  logic               req_mapped,
    input  logic [WORD_W-1:0]  req_wdata,
    input  logic [WORD_W-1:0]  mem_rdata,
    input  logic               cfg_blk12,
    input  logic [NUM_BUF-1:0] cfg_pack_en,
    input  logic [NUM_BUF-1:0] cfg_pack_lsb,
    input  logic [LANE_W-1:0]  cfg_alpha,
    input  logic [WORD_W-1:0]  cfg_dflt_word,
    output logic               wr_valid,
    output logic [LANES-1:0]   wr_strb,
    output logic [WORD_W-1:0]  wr_data,
    output logic               rd_valid,
    output logic [WORD_W-1:0]  rd_data
);

    pack_mode_e        acc_mode;
    logic [LANES-1:0]  acc_strb;
    logic [WORD_W-1:0] acc_merged;

    beat_state_e       state_q, state_d;
    logic [WORD_W-1:0] beat_q, beat_d;
    logic [LANES-1:0]  strb_q;

    gfx_pack_mode_sel #(
        .NUM_BUF (NUM_BUF),
        .IDX_W   (IDX_W)
    ) u_mode (
        .buf_idx  (req_buf),
        .blk12    (cfg_blk12),
        .pack_en  (cfg_pack_en),
        .pack_lsb (cfg_pack_lsb),
        .mode     (acc_mode)
    );

    gfx_pack_lane_strobe #(
        .LANES (LANES)
    ) u_strb (
        .mode (acc_mode),
        .strb (acc_strb)
    );

    gfx_pack_read_merge #(
        .WORD_W (WORD_W),
        .LANE_W (LANE_W)
    ) u_merge (
        .mode     (acc_mode),
        .mem_word (mem_rdata),
        .alpha    (cfg_alpha),
        .merged   (acc_merged)
    );

    // Next result state and the word held for it
    always_comb begin
        state_d = ST_IDLE;
        beat_d  = beat_q;
        if (req_valid) begin
            unique case ({req_write, req_mapped})
                2'b11: begin
                    state_d = ST_WR_PASS;
                    beat_d  = req_wdata;
                end
                2'b10: begin
                    state_d = ST_WR_DROP;
                    beat_d  = req_wdata;
                end
                2'b01: begin
                    state_d = ST_RD_MAPPED;
                    beat_d  = acc_merged;
                end
                default: begin
                    state_d = ST_RD_DEFAULT;
                    beat_d  = cfg_dflt_word;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            strb_q  <= '0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
            strb_q  <= acc_strb;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        wr_valid = 1'b0;
        wr_strb  = '0;
        wr_data  = '0;
        rd_valid = 1'b0;
        rd_data  = '0;
        unique case (state_q)
            ST_WR_PASS: begin
                wr_valid = 1'b1;
                wr_strb  = strb_q;
                wr_data  = beat_q;
            end
            ST_WR_DROP: begin
                wr_valid = 1'b1;
                wr_data  = beat_q;
            end
            ST_RD_MAPPED, ST_RD_DEFAULT: begin
                rd_valid = 1'b1;
                rd_data  = beat_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/gfx_pack_path_chk.sv
module gfx_pack_path_chk #(
    parameter int NUM_BUF = 4,
    parameter int WORD_W  = 32,
    parameter int LANES   = 4,
    parameter int IDX_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_write,
    input logic               req_mapped,
    input logic               cfg_blk12,
    input logic [WORD_W-1:0]  cfg_dflt_word,
    input logic [WORD_W-1:0]  mem_rdata,
    input logic               wr_valid,
    input logic [LANES-1:0]   wr_strb,
    input logic               rd_valid,
    input logic [WORD_W-1:0]  rd_data
);

    localparam logic [LANES-1:0] ALL_ON  = '1;
    localparam logic [LANES-1:0] HI_OFF  = ALL_ON >> 1;
    localparam logic [LANES-1:0] LO_OFF  = ALL_ON << 1;

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ($countones({wr_valid, rd_valid}) == 1)); // R10

    AST_QUIET_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!wr_valid && !rd_valid)); // R10

    AST_WRITE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> wr_valid); // R10

    AST_NO_STRB_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |-> (wr_strb == '0)); // R1

    AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_mapped) |=> (wr_strb == '0)); // R8

    AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !req_mapped) |=> (rd_data == $past(cfg_dflt_word))); // R9

    AST_WIDE_BLOCK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_mapped && !cfg_blk12) |=> (wr_strb == ALL_ON)); // R2

    AST_WIDE_BLOCK_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_mapped && !cfg_blk12) |=> (rd_data == $past(mem_rdata))); // R2

    AST_STRB_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_strb == ALL_ON || wr_strb == HI_OFF
                      || wr_strb == LO_OFF || wr_strb == '0)); // R3 R4

endmodule

bind gfx_pack_path gfx_pack_path_chk #(
    .NUM_BUF (NUM_BUF),
    .WORD_W  (WORD_W),
    .LANES   (LANES),
    .IDX_W   (IDX_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_mapped    (req_mapped),
    .cfg_blk12     (cfg_blk12),
    .cfg_dflt_word (cfg_dflt_word),
    .mem_rdata     (mem_rdata),
    .wr_valid      (wr_valid),
    .wr_strb       (wr_strb),
    .rd_valid      (rd_valid),
    .rd_data       (rd_data)
);

// File: tb/gfx_pack_path_tb.sv
module gfx_pack_path_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_buf = '0;
    logic        req_mapped = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [31:0] mem_rdata = '0;
    logic        cfg_blk12 = 1'b0;
    logic [3:0]  cfg_pack_en = '0;
    logic [3:0]  cfg_pack_lsb = '0;
    logic [7:0]  cfg_alpha = '0;
    logic [31:0] cfg_dflt_word = '0;
    logic        wr_valid;
    logic [3:0]  wr_strb;
    logic [31:0] wr_data;
    logic        rd_valid;
    logic [31:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    gfx_pack_path u_dut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_write (req_write), .req_buf (req_buf),
        .req_mapped (req_mapped), .req_wdata (req_wdata), .mem_rdata (mem_rdata),
        .cfg_blk12 (cfg_blk12), .cfg_pack_en (cfg_pack_en),
        .cfg_pack_lsb (cfg_pack_lsb), .cfg_alpha (cfg_alpha),
        .cfg_dflt_word (cfg_dflt_word),
        .wr_valid (wr_valid), .wr_strb (wr_strb), .wr_data (wr_data),
        .rd_valid (rd_valid), .rd_data (rd_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // 0 = whole word, 1 = top byte dropped, 2 = bottom byte dropped
    function automatic int exp_mode(input logic [1:0] b);
        if (!cfg_blk12 || !cfg_pack_en[b]) return 0;
        return cfg_pack_lsb[b] ? 2 : 1;
    endfunction

    function automatic string mode_tag(input int m, input bit wr);
        if (m == 1) return wr ? "R3" : "R5";
        if (m == 2) return wr ? "R4" : "R6";
        return cfg_blk12 ? "R11" : "R2";
    endfunction

    // Drive one access, let it be captured, then check the result cycle
    task automatic access(input bit wr, input logic [1:0] b, input bit mapped,
                          input logic [31:0] wd, input logic [31:0] md);
        int m;
        logic [3:0]  e_strb;
        logic [31:0] e_rd;
        req_valid = 1'b1; req_write = wr; req_buf = b;
        req_mapped = mapped; req_wdata = wd; mem_rdata = md;
        m = exp_mode(b);
        e_strb = (m == 1) ? 4'b0111 : (m == 2) ? 4'b1110 : 4'b1111;
        e_rd = (m == 1) ? {cfg_alpha, md[23:0]}
             : (m == 2) ? {md[31:8], cfg_alpha} : md;
        @(posedge clk);
        @(negedge clk);
        check("R10", {30'd0, wr_valid, rd_valid}, wr ? 32'd2 : 32'd1);
        if (wr && mapped) begin
            check(mode_tag(m, 1'b1), {28'd0, wr_strb}, {28'd0, e_strb});
            check("R12", wr_data, wd);
        end else if (wr) begin
            check("R8", {28'd0, wr_strb}, 32'd0);
        end else if (mapped) begin
            check(mode_tag(m, 1'b0), rd_data, e_rd);
        end else begin
            check("R9", rd_data, cfg_dflt_word);
        end
    endtask

    task automatic idle_cycle();
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R10", {30'd0, wr_valid, rd_valid}, 32'd0);
        check("R1", {28'd0, wr_strb}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R10: watchdog expired, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", {30'd0, wr_valid, rd_valid}, 32'd0);
        check("R1", {28'd0, wr_strb}, 32'd0);
        // R9: defaults are zero after reset
        access(1'b0, 2'd0, 1'b0, 32'h0, 32'hDEADBEEF);

        // Directed corners
        cfg_alpha = 8'hA5; cfg_dflt_word = 32'hCAFE_F00D;
        cfg_pack_en = 4'b1111; cfg_pack_lsb = 4'b0101;
        cfg_blk12 = 1'b0;                                   // R2: enables ignored
        access(1'b1, 2'd0, 1'b1, 32'h1122_3344, 32'h0);
        access(1'b0, 2'd1, 1'b1, 32'h0, 32'h5566_7788);
        cfg_blk12 = 1'b1;
        access(1'b1, 2'd1, 1'b1, 32'h99AA_BBCC, 32'h0);     // R3
        access(1'b1, 2'd0, 1'b1, 32'h99AA_BBCC, 32'h0);     // R4
        access(1'b0, 2'd3, 1'b1, 32'h0, 32'h0102_0304);     // R5
        access(1'b0, 2'd2, 1'b1, 32'h0, 32'h0102_0304);     // R6
        // R7: neighbours opposite, only buffer 2 disabled
        cfg_pack_en = 4'b1011; cfg_pack_lsb = 4'b1011;
        access(1'b1, 2'd2, 1'b1, 32'hFFEE_DDCC, 32'h0);     // R11
        access(1'b0, 2'd2, 1'b1, 32'h0, 32'h1357_9BDF);     // R11
        access(1'b1, 2'd3, 1'b0, 32'h2468_ACE0, 32'h0);     // R8
        access(1'b0, 2'd0, 1'b0, 32'h0, 32'h7777_7777);     // R9 while packed
        idle_cycle();
        idle_cycle();

        // Constrained random
        for (int i = 0; i < 2500; i++) begin
            cfg_blk12     = $urandom_range(0, 3) != 0;
            cfg_pack_en   = 4'($urandom);
            cfg_pack_lsb  = 4'($urandom);
            cfg_alpha     = 8'($urandom);
            cfg_dflt_word = $urandom;
            if ($urandom_range(0, 9) == 0) begin
                idle_cycle();
            end else begin
                access(1'($urandom), 2'($urandom), $urandom_range(0, 4) != 0,
                       $urandom, $urandom);
            end
        end
        idle_cycle();

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule